// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the tap setting of a 512-position programmable delay line as a 9-bit count and reports it on an output bus at all times. Software or calibration logic can move the setting one tap per control clock, jump it to a supplied value, or send it back to a built-in default through an asynchronous delay reset. Every control is sampled on the rising edge of one dedicated control clock.

A two-bit mode input picks one of three behaviours. In fixed mode the setting never moves. In step mode only single-tap steps are honoured. In step-and-load mode jumps are honoured as well. A jump is accepted only under three conditions: the step enable is low, the voltage/temperature compensation enable is low, and the new value lies no more than 8 taps from the current one, measured the short way round the 512-tap circle. A jump request that breaks any of these conditions leaves the setting unchanged and raises a one-cycle violation flag. The count wraps in both directions.

Top module: `tap_delay_ctrl`

## Requirements
- R1: Raising `rst_dly` immediately forces `tap_out` to the default (parameter `DEFAULT_TAP`, 64) and clears `viol`. The block stays in reset until the second rising edge after `rst_dly` falls.
- R2: With `mode` = 01 (step) or 10 (step-and-load), `ce` = 1 and no load request, every rising edge moves `tap_out` up one tap when `inc` = 1 and down one tap when `inc` = 0. The new value is visible after that edge.
- R3: With `ce` = 0 and no accepted load, `tap_out` does not change, whatever `inc` is.
- R4: A step up from 511 gives 0, and a step down from 0 gives 511.
- R5: In mode 10, `load` = 1 copies `tap_in` into `tap_out` at the edge, provided `ce` = 0, `vt_en` = 0 and the circular distance is at most 8.
- R6: Modes 00 and 11 are fixed: `ce`, `inc` and `load` have no effect and `viol` stays low. In mode 01, `load` is ignored and raises no flag.
- R7: A load request in mode 10 while `vt_en` = 1 is ignored and flagged.
- R8: A load request in mode 10 while `ce` = 1 is ignored and flagged, and no step occurs on that edge.
- R9: A load whose circular distance (the smaller of the two ways round 512 taps) exceeds 8 is ignored and flagged. A distance of exactly 8, including one across the 511/0 boundary, is accepted.
- R10: `viol` is registered. It is high for exactly the cycle after each edge that sampled a flagged request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock; all controls are sampled on its rising edge |
| rst_dly | input | 1 | Active-high delay reset; asserts asynchronously, released synchronously |
| mode | input | 2 | 00 fixed, 01 step, 10 step-and-load, 11 fixed |
| ce | input | 1 | Step enable |
| inc | input | 1 | Step direction: 1 up, 0 down |
| load | input | 1 | Load request |
| vt_en | input | 1 | Compensation enable; blocks loads while high |
| tap_in | input | 9 | Value to load |
| tap_out | output | 9 | Current tap setting |
| viol | output | 1 | Registered protocol-violation flag |

## Verification
The assertions take for granted that the controls are stable and defined around each rising clock edge while the synchronized reset is released. They also assume `mode` may change from cycle to cycle, so every property compares only adjacent edges. The stimulus changes inputs only on falling edges and holds them through the next rising edge. It raises `rst_dly` only between edges, and it keeps `tap_in` defined on every cycle, so the circular distance check never sees unknown bits.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_STEP  = 2'b01,
    MODE_VLOAD = 2'b10,
    MODE_RSVD  = 2'b11
  } tdc_mode_e;
endpackage

// File: rtl/tdc_rst_sync.sv
`timescale 1ns/1ps
module tdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh_q <= '1;
    else      sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign rst = sh_q[STAGES-1];
endmodule

// File: rtl/tdc_decode.sv
`timescale 1ns/1ps
module tdc_decode
  import tdc_pkg::*;
#(
  parameter int TAP_W    = 9,
  parameter int MAX_JUMP = 8
) (
  input  logic [1:0]       mode,
  input  logic             ce,
  input  logic             inc,
  input  logic             load,
  input  logic             vt_en,
  input  logic [TAP_W-1:0] tap_cur,
  input  logic [TAP_W-1:0] tap_in,
  output logic             step_ev,
  output logic             load_ev,
  output logic             viol_ev,
  output logic [TAP_W-1:0] tap_next
);
  localparam logic [TAP_W-1:0] ONE      = {{(TAP_W-1){1'b0}}, 1'b1};
  localparam logic [TAP_W-1:0] JUMP_LIM = TAP_W'(MAX_JUMP);

  // shortest way round the tap circle
  function automatic logic [TAP_W-1:0] circ_dist(input logic [TAP_W-1:0] a,
                                                 input logic [TAP_W-1:0] b);
    logic [TAP_W-1:0] fwd, bwd;
    fwd = a - b;
    bwd = b - a;
    return (fwd < bwd) ? fwd : bwd;
  endfunction

  function automatic logic [TAP_W-1:0] step_tap(input logic [TAP_W-1:0] t,
                                                input logic up);
    return up ? (t + ONE) : (t - ONE);
  endfunction

  logic is_vload, is_active, load_req, too_far, bad;

  always_comb begin
    is_vload  = (mode == MODE_VLOAD);
    is_active = (mode == MODE_STEP) || (mode == MODE_VLOAD);
    load_req  = is_vload && load;
    too_far   = circ_dist(tap_in, tap_cur) > JUMP_LIM;
    bad       = load_req && (ce || vt_en || too_far);
    load_ev   = load_req && !bad;
    viol_ev   = bad;
    step_ev   = is_active && ce && !load_req;
    if (load_ev)      tap_next = tap_in;
    else if (step_ev) tap_next = step_tap(tap_cur, inc);
    else              tap_next = tap_cur;
  end
endmodule

// File: rtl/tdc_tap_reg.sv
`timescale 1ns/1ps
module tdc_tap_reg #(
  parameter int TAP_W       = 9,
  parameter int DEFAULT_TAP = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tap_next,
  input  logic             viol_ev,
  output logic [TAP_W-1:0] tap_q,
  output logic             viol_q
);
  localparam logic [TAP_W-1:0] TAP_RST = TAP_W'(DEFAULT_TAP);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tap_q  <= TAP_RST;
      viol_q <= 1'b0;
    end else begin
      tap_q  <= tap_next;
      viol_q <= viol_ev;
    end
  end
endmodule

// File: rtl/tap_delay_ctrl.sv
`timescale 1ns/1ps
module tap_delay_ctrl #(
  parameter int TAP_W       = 9,
  parameter int MAX_JUMP    = 8,
  parameter int DEFAULT_TAP = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_dly,
  input  logic [1:0]       mode,
  input  logic             ce,
  input  logic             inc,
  input  logic             load,
  input  logic             vt_en,
  input  logic [TAP_W-1:0] tap_in,
  output logic [TAP_W-1:0] tap_out,
  output logic             viol
);
  logic             rst_int;
  logic             step_ev, load_ev, viol_ev;
  logic [TAP_W-1:0] tap_next;

  tdc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk (clk),
    .arst(rst_dly),
    .rst (rst_int)
  );

  tdc_decode #(.TAP_W(TAP_W), .MAX_JUMP(MAX_JUMP)) u_dec (
    .mode    (mode),
    .ce      (ce),
    .inc     (inc),
    .load    (load),
    .vt_en   (vt_en),
    .tap_cur (tap_out),
    .tap_in  (tap_in),
    .step_ev (step_ev),
    .load_ev (load_ev),
    .viol_ev (viol_ev),
    .tap_next(tap_next)
  );

  tdc_tap_reg #(.TAP_W(TAP_W), .DEFAULT_TAP(DEFAULT_TAP)) u_reg (
    .clk     (clk),
    .rst     (rst_int),
    .tap_next(tap_next),
    .viol_ev (viol_ev),
    .tap_q   (tap_out),
    .viol_q  (viol)
  );
endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker #(
  parameter int TAP_W       = 9,
  parameter int MAX_JUMP    = 8,
  parameter int DEFAULT_TAP = 64
) (
  input logic             clk,
  input logic             rst_int,
  input logic [1:0]       mode,
  input logic             ce,
  input logic             inc,
  input logic             load,
  input logic             vt_en,
  input logic [TAP_W-1:0] tap_in,
  input logic [TAP_W-1:0] tap_out,
  input logic             viol,
  input logic             step_ev,
  input logic             load_ev,
  input logic             viol_ev
);
  localparam logic [TAP_W-1:0] ONE      = {{(TAP_W-1){1'b0}}, 1'b1};
  localparam logic [TAP_W-1:0] JUMP_LIM = TAP_W'(MAX_JUMP);
  localparam logic [TAP_W-1:0] TAP_RST  = TAP_W'(DEFAULT_TAP);

  function automatic logic [TAP_W-1:0] span(input logic [TAP_W-1:0] a,
                                            input logic [TAP_W-1:0] b);
    logic [TAP_W-1:0] up, dn;
    up = a - b;
    dn = b - a;
    return (up < dn) ? up : dn;
  endfunction

  p_reset_val_r1: assert property (@(posedge clk)
    rst_int |-> (tap_out == TAP_RST) && !viol);

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst_int)
    step_ev && inc |=> tap_out == $past(tap_out) + ONE);

  p_step_dn_r4: assert property (@(posedge clk) disable iff (rst_int)
    step_ev && !inc |=> tap_out == $past(tap_out) - ONE);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst_int)
    !ce && !load_ev |=> $stable(tap_out));

  p_load_copy_r5: assert property (@(posedge clk) disable iff (rst_int)
    load_ev |=> tap_out == $past(tap_in));

  p_fixed_mode_r6: assert property (@(posedge clk) disable iff (rst_int)
    (mode == 2'b00 || mode == 2'b11) |=> $stable(tap_out) && !viol);

  p_vt_block_r7: assert property (@(posedge clk) disable iff (rst_int)
    load && vt_en |-> !load_ev);

  p_ce_block_r8: assert property (@(posedge clk) disable iff (rst_int)
    load && ce && mode == 2'b10 |-> !load_ev && !step_ev);

  p_jump_lim_r9: assert property (@(posedge clk) disable iff (rst_int)
    load_ev |=> span(tap_out, $past(tap_out)) <= JUMP_LIM);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst_int)
    viol_ev |=> viol && $stable(tap_out));

  p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst_int)
    !viol_ev |=> !viol);
endmodule

bind tap_delay_ctrl tdc_checker #(
  .TAP_W(TAP_W), .MAX_JUMP(MAX_JUMP), .DEFAULT_TAP(DEFAULT_TAP)
) u_chk (
  .clk    (clk),
  .rst_int(rst_int),
  .mode   (mode),
  .ce     (ce),
  .inc    (inc),
  .load   (load),
  .vt_en  (vt_en),
  .tap_in (tap_in),
  .tap_out(tap_out),
  .viol   (viol),
  .step_ev(step_ev),
  .load_ev(load_ev),
  .viol_ev(viol_ev)
);

// File: tb/sim_tap_delay_ctrl.sv
`timescale 1ns/1ps
module sim_tap_delay_ctrl;
  localparam int TW   = 9;
  localparam int NT   = 1 << TW;
  localparam int DEF  = 64;
  localparam int JUMP = 8;

  logic          clk = 1'b0;
  logic          rst_dly = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          ce = 1'b0, inc = 1'b0, load = 1'b0, vt_en = 1'b0;
  logic [TW-1:0] tap_in = '0;
  logic [TW-1:0] tap_out;
  logic          viol;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [TW-1:0] tap;
    logic          flag;
    string         tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  int mt = DEF;   // reference tap

  always #2.5 clk = ~clk;

  tap_delay_ctrl u0 (
    .clk(clk), .rst_dly(rst_dly), .mode(mode), .ce(ce), .inc(inc),
    .load(load), .vt_en(vt_en), .tap_in(tap_in), .tap_out(tap_out),
    .viol(viol)
  );

  function automatic int ring_gap(int a, int b);
    int d = ((a - b) % NT + NT) % NT;
    if (d > NT / 2) d = NT - d;
    return d;
  endfunction

  task automatic chk(input string tag, input int got_t, input int exp_tap,
                     input int got_v, input int exp_v);
    checks++;
    if (got_t != exp_tap || got_v != exp_v) begin
      errors++;
      $display("FAIL %s tap=%0d viol=%0d expected tap=%0d viol=%0d",
               tag, got_t, got_v, exp_tap, exp_v);
    end
  endtask

  // driver: apply one cycle of controls, predict, push expectation
  task automatic drive(input logic [1:0] m, input logic c, input logic i,
                       input logic l, input logic v, input int tin,
                       input string tag);
    exp_t e;
    int   nt;
    bit   nv;
    @(negedge clk);
    mode = m; ce = c; inc = i; load = l; vt_en = v; tap_in = TW'(tin);
    nt = mt;
    nv = 0;
    if (m == 2'b10 && l) begin
      if (c || v || ring_gap(tin, mt) > JUMP) nv = 1;
      else nt = tin;
    end else if ((m == 2'b01 || m == 2'b10) && c) begin
      nt = i ? (mt + 1) % NT : (mt + NT - 1) % NT;
    end
    mt = nt;
    @(posedge clk);
    #1;
    e.tap = TW'(nt);
    e.flag = nv;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      chk(cur.tag, int'(tap_out), int'(cur.tap), int'(viol), int'(cur.flag));
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_dly = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", int'(tap_out), DEF, int'(viol), 0);

    // R2 steps
    for (int k = 0; k < 5; k++) drive(2'b01, 1, 1, 0, 0, 0, "R2 step up");
    for (int k = 0; k < 3; k++) drive(2'b10, 1, 0, 0, 0, 0, "R2 step down");
    // R3 enable low
    for (int k = 0; k < 4; k++) drive(2'b01, 0, k[0], 0, 0, 0, "R3 hold");
    // R5 / R9 loads
    drive(2'b10, 0, 0, 1, 0, (mt + 8) % NT, "R9 load dist 8 accepted");
    drive(2'b10, 0, 0, 1, 0, (mt + NT - 5) % NT, "R5 load accepted");
    drive(2'b10, 0, 0, 0, 0, 0, "R10 flag low after good load");
    drive(2'b10, 0, 0, 1, 0, (mt + 9) % NT, "R9 load dist 9 rejected");
    drive(2'b10, 0, 0, 0, 0, 0, "R10 flag one cycle");
    drive(2'b10, 0, 0, 1, 1, (mt + 2) % NT, "R7 load with vt_en");
    drive(2'b10, 1, 1, 1, 0, (mt + 2) % NT, "R8 load with ce");
    // R6 fixed modes and load in step mode
    drive(2'b01, 0, 0, 1, 0, (mt + 3) % NT, "R6 load ignored in step mode");
    drive(2'b00, 1, 1, 1, 0, (mt + 3) % NT, "R6 fixed mode 00");
    drive(2'b11, 1, 0, 1, 1, (mt + 3) % NT, "R6 fixed mode 11");
    drive(2'b00, 1, 0, 0, 0, 0, "R6 fixed mode step");
    // R4 wrap both ways
    while (mt != 2) drive(2'b01, 1, 0, 0, 0, 0, "R4 descend");
    for (int k = 0; k < 4; k++) drive(2'b01, 1, 0, 0, 0, 0, "R4 wrap down");
    for (int k = 0; k < 4; k++) drive(2'b10, 1, 1, 0, 0, 0, "R4 wrap up");
    // R9 circular distance across boundary
    while (mt != 3) drive(2'b01, 1, (mt < 3) || (mt > 300), 0, 0, 0, "R2 position");
    drive(2'b10, 0, 0, 1, 0, 507, "R9 wrapped dist 8 accepted");
    drive(2'b10, 0, 0, 1, 0, 4, "R9 wrapped dist 9 rejected");
    drive(2'b10, 0, 0, 1, 0, 2, "R5 wrapped load accepted");
    drive(2'b01, 0, 1, 0, 0, 0, "R3 hold after load");

    // R1 asynchronous reset mid-run
    drain();
    @(posedge clk);
    #1.2 rst_dly = 1'b1;
    #0.3 chk("R1 async reset", int'(tap_out), DEF, int'(viol), 0);
    mt = DEF;
    @(negedge clk);
    rst_dly = 1'b0;
    for (int k = 0; k < 3; k++) drive(2'b01, 0, 1, 0, 0, 0, "R1 reset release");
    drive(2'b01, 1, 1, 0, 0, 0, "R1 step after release");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule